// File: doc/BRIEF.md
# Dual-Pipeline Stage Checker and Recovery

This block guards one stage boundary shared by a main pipeline and a shadow pipeline. A routing mux selects what the shadow pipeline register captures, depending on a per-unit protection mode:

- In late-sampling mode it captures the main stage's own result at a delayed strobe within the same clock period.
- In full replication mode it captures the shadow stage's independently computed result.

During the cycle after capture, a lane-split comparator checks the two registered words. Only pairs where both halves are valid are compared.

When the compare fails, the recovery controller picks one action for that cycle:

- It stalls and loads the main register with the shadow value.
- It requests a pipeline flush.
- It requests a reissue of the instruction.

The choice depends on the mode, on whether the stage lies before or after operand scheduling (a build-time parameter), and on an error marker. Full-replication failures set a marker on the stage. A retried instruction arrives with its own marker bit. If a marked instruction fails again in a marked stage, the failure is taken to be timing-related and the shadow copy is forwarded rather than retried.

The delayed capture edge is modelled by a separate strobe input that clocks the shadow register. The environment holds the main result stable at its late-settled value until that strobe. Downstream logic treats the main register word as unusable in any cycle where stall, flush or reissue is high.

Top module: `dual_stage_guard`

## Requirements
- R1: While reset is asserted (asynchronous, active low) and right after it, q_vld_o is 0 and stall_o, flush_o, reissue_o and err_o are 0.
- R2: With mode_i = 2'b11 (no replication) or 2'b00 (treated the same), the main register captures main_res_i every cycle, and err_o, stall_o, flush_o and reissue_o stay 0 whatever the shadow inputs are.
- R3: With mode_i = 2'b10 (late sampling), the main register samples main_res_i at the clock edge and the shadow register samples main_res_i, not shad_res_i, at the next rising edge of late_stb_i. If the two differ, err_o and stall_o are high during the cycle after that clock edge.
- R4: At the clock edge that ends a stall cycle, the main register is loaded with the shadow register word and the input is ignored. In the following cycle no compare is made, so one error costs a single stall cycle.
- R5: With mode_i = 2'b01 (full replication), the shadow register samples shad_res_i at late_stb_i. In the post-scheduling variant (AFTER_RS=1), a mismatch that is not a repeat raises err_o and reissue_o for one cycle, sets the stage marker, and does not forward the shadow word.
- R6: In the pre-scheduling variant (AFTER_RS=0), the same mismatch raises flush_o instead of reissue_o, and the word presented at the clock edge ending that cycle is dropped, so q_vld_o is 0 in the next cycle.
- R7: In full replication, a mismatch on an instruction whose marker bit (main_mark_i captured with it) is 1, while the stage marker is set, raises stall_o instead of flush/reissue and forwards the shadow word as in R4. The stage marker is then cleared.
- R8: A marked instruction that passes the full-replication compare clears the stage marker. A later marked mismatch then gets flush/reissue, not stall.
- R9: A compare is made only when both the main and the shadow register hold valid words. A bubble never raises err_o or any action.
- R10: At most one of stall_o, flush_o and reissue_o is high in any cycle, and neither stall_o nor flush_o is high on two consecutive cycles.
- R11: Every data bit takes part in the compare: a difference in bit 0 alone or in the top bit alone is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stage clock; main register and controller |
| rst_ni | input | 1 | Asynchronous active-low reset |
| late_stb_i | input | 1 | Delayed capture strobe; rising edge clocks the shadow register |
| mode_i | input | 2 | Protection mode: 01 full, 10 late sampling, 11/00 off |
| main_res_i | input | DATA_W | Main stage combinational result |
| main_vld_i | input | 1 | Main result carries an instruction |
| main_mark_i | input | 1 | Error marker bit of the incoming instruction |
| shad_res_i | input | DATA_W | Shadow stage combinational result |
| shad_vld_i | input | 1 | Shadow result carries an instruction |
| q_o | output | DATA_W | Main pipeline register data |
| q_vld_o | output | 1 | Main pipeline register valid |
| stall_o | output | 1 | Stall pulse; main register is reloaded from shadow |
| flush_o | output | 1 | Full flush and re-execution request |
| reissue_o | output | 1 | Discard and reissue request |
| err_o | output | 1 | A checked mismatch was seen this cycle |

## Verification
The hardest case to reach is the repeat-error forward. It needs the following sequence in full replication mode:

1. An unmarked mismatch, to set the stage marker.
2. At least one clean unmarked word in between.
3. The marked retry, which fails again.

The stimulus table walks exactly that sequence. It then checks that the stall forwards the shadow word and that a later marked failure falls back to reissue once a clean marked pass has cleared the marker.

Timing errors need the main result to change between the clock edge and the late strobe. The bench therefore drives an early value before each edge and a late-settled value before each strobe. A pre-scheduling instance shares the stimulus, so the flush variant and its dropped word are checked row by row.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

    // Per-unit protection mode; encodings are fixed by the mode select wiring.
    typedef enum logic [1:0] {
        PM_OFF_ALT = 2'b00,
        PM_FULL    = 2'b01,
        PM_LATE    = 2'b10,
        PM_OFF     = 2'b11
    } prot_mode_e;

    // Recovery action chosen for the current compare cycle.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_FWD     = 2'd1,
        ACT_FLUSH   = 2'd2,
        ACT_REISSUE = 2'd3
    } act_e;

    function automatic logic mode_checked(input prot_mode_e m);
        return (m == PM_FULL) || (m == PM_LATE);
    endfunction

endpackage

// File: rtl/dsg_route.sv
module dsg_route
    import dsg_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] main_res_i,
    input  logic              main_vld_i,
    input  logic [DATA_W-1:0] shad_res_i,
    input  logic              shad_vld_i,
    output logic [DATA_W-1:0] sel_data_o,
    output logic              sel_vld_o
);

    prot_mode_e mode;
    assign mode = prot_mode_e'(mode_i);

    // Late sampling reuses the main logic output; full replication takes the
    // shadow logic; with protection off the shadow register holds a bubble.
    always_comb begin
        sel_data_o = '0;
        sel_vld_o  = 1'b0;
        unique case (mode)
            PM_LATE: begin
                sel_data_o = main_res_i;
                sel_vld_o  = main_vld_i;
            end
            PM_FULL: begin
                sel_data_o = shad_res_i;
                sel_vld_o  = shad_vld_i;
            end
            default: begin
                sel_data_o = '0;
                sel_vld_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dsg_shadow_reg.sv
module dsg_shadow_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              late_stb_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] d_data_i,
    input  logic              d_vld_i,
    output logic [DATA_W-1:0] q_data_o,
    output logic              q_vld_o
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } sh_word_t;

    sh_word_t sh_d, sh_q;

    always_comb begin
        sh_d.vld  = d_vld_i;
        sh_d.data = d_data_i;
    end

    // Clocked by the delayed strobe: samples later in the period than the main register.
    always_ff @(posedge late_stb_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q_data_o = sh_q.data;
    assign q_vld_o  = sh_q.vld;

endmodule

// File: rtl/dsg_compare.sv
module dsg_compare #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              a_vld_i,
    input  logic              b_vld_i,
    output logic              both_vld_o,
    output logic              mism_o
);

    localparam int unsigned LANES = (DATA_W + LANE_W - 1) / LANE_W;

    logic [LANES-1:0] lane_diff;

    // Each lane reduces its own slice; the last lane may be narrower.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned LO = g * LANE_W;
        localparam int unsigned HI = ((g + 1) * LANE_W > DATA_W) ? DATA_W - 1
                                                                  : (g + 1) * LANE_W - 1;
        assign lane_diff[g] = |(a_i[HI:LO] ^ b_i[HI:LO]);
    end

    assign both_vld_o = a_vld_i & b_vld_i;
    assign mism_o     = both_vld_o & (|lane_diff);

endmodule

// File: rtl/dsg_recover.sv
module dsg_recover
    import dsg_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter bit          AFTER_RS = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] main_res_i,
    input  logic              main_vld_i,
    input  logic              main_mark_i,
    input  logic [DATA_W-1:0] shad_data_i,
    input  logic              both_vld_i,
    input  logic              mism_i,
    output logic [DATA_W-1:0] q_o,
    output logic              q_vld_o,
    output logic              stall_o,
    output logic              flush_o,
    output logic              reissue_o,
    output logic              err_o
);

    typedef struct packed {
        logic              vld;
        logic              mark;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef struct packed {
        word_t main;
        logic  stage_mark;
        logic  rec;
    } state_t;

    state_t     st_d, st_q;
    prot_mode_e mode;
    act_e       fail_act;
    act_e       act;
    logic       checked;
    logic       live;
    logic       repeat_hit;
    logic       clean_mark;

    assign mode = prot_mode_e'(mode_i);

    // Stage position picks the non-repeat response to a replicated mismatch.
    if (AFTER_RS) begin : g_post
        assign fail_act = ACT_REISSUE;
    end else begin : g_pre
        assign fail_act = ACT_FLUSH;
    end

    always_comb begin
        checked    = mode_checked(mode);
        live       = checked && mism_i && !st_q.rec;
        repeat_hit = st_q.main.mark && st_q.stage_mark;
        clean_mark = (mode == PM_FULL) && both_vld_i && !mism_i
                     && st_q.main.mark && !st_q.rec;

        act = ACT_NONE;
        if (live) begin
            if (mode == PM_LATE) begin
                act = ACT_FWD;
            end else if (repeat_hit) begin
                act = ACT_FWD;
            end else begin
                act = fail_act;
            end
        end

        st_d.main.vld  = main_vld_i;
        st_d.main.mark = main_mark_i;
        st_d.main.data = main_res_i;
        st_d.stage_mark = st_q.stage_mark;
        st_d.rec        = 1'b0;

        unique case (act)
            ACT_FWD: begin
                st_d.main.vld  = 1'b1;
                st_d.main.mark = st_q.main.mark;
                st_d.main.data = shad_data_i;
                st_d.rec       = 1'b1;
                if (mode == PM_FULL) begin
                    st_d.stage_mark = 1'b0;
                end
            end
            ACT_FLUSH: begin
                st_d.main.vld   = 1'b0;
                st_d.stage_mark = 1'b1;
            end
            ACT_REISSUE: begin
                st_d.stage_mark = 1'b1;
            end
            default: begin
                if (clean_mark) begin
                    st_d.stage_mark = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o       = st_q.main.data;
    assign q_vld_o   = st_q.main.vld;
    assign stall_o   = (act == ACT_FWD);
    assign flush_o   = (act == ACT_FLUSH);
    assign reissue_o = (act == ACT_REISSUE);
    assign err_o     = live;

endmodule

// File: rtl/dual_stage_guard.sv
module dual_stage_guard
    import dsg_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned LANE_W   = 4,
    parameter bit          AFTER_RS = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              late_stb_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] main_res_i,
    input  logic              main_vld_i,
    input  logic              main_mark_i,
    input  logic [DATA_W-1:0] shad_res_i,
    input  logic              shad_vld_i,
    output logic [DATA_W-1:0] q_o,
    output logic              q_vld_o,
    output logic              stall_o,
    output logic              flush_o,
    output logic              reissue_o,
    output logic              err_o
);

    logic [DATA_W-1:0] route_data;
    logic              route_vld;
    logic [DATA_W-1:0] shad_q_data;
    logic              shad_q_vld;
    logic              both_vld;
    logic              mism;

    dsg_route #(.DATA_W(DATA_W)) route_i (
        .mode_i     (mode_i),
        .main_res_i (main_res_i),
        .main_vld_i (main_vld_i),
        .shad_res_i (shad_res_i),
        .shad_vld_i (shad_vld_i),
        .sel_data_o (route_data),
        .sel_vld_o  (route_vld)
    );

    dsg_shadow_reg #(.DATA_W(DATA_W)) shadow_i (
        .late_stb_i (late_stb_i),
        .rst_ni     (rst_ni),
        .d_data_i   (route_data),
        .d_vld_i    (route_vld),
        .q_data_o   (shad_q_data),
        .q_vld_o    (shad_q_vld)
    );

    dsg_compare #(.DATA_W(DATA_W), .LANE_W(LANE_W)) cmp_i (
        .a_i        (q_o),
        .b_i        (shad_q_data),
        .a_vld_i    (q_vld_o),
        .b_vld_i    (shad_q_vld),
        .both_vld_o (both_vld),
        .mism_o     (mism)
    );

    dsg_recover #(.DATA_W(DATA_W), .AFTER_RS(AFTER_RS)) rec_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_i      (mode_i),
        .main_res_i  (main_res_i),
        .main_vld_i  (main_vld_i),
        .main_mark_i (main_mark_i),
        .shad_data_i (shad_q_data),
        .both_vld_i  (both_vld),
        .mism_i      (mism),
        .q_o         (q_o),
        .q_vld_o     (q_vld_o),
        .stall_o     (stall_o),
        .flush_o     (flush_o),
        .reissue_o   (reissue_o),
        .err_o       (err_o)
    );

endmodule

// File: rtl/dsg_checker.sv
module dsg_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [1:0]        mode_i,
    input logic [DATA_W-1:0] q_o,
    input logic              q_vld_o,
    input logic              stall_o,
    input logic              flush_o,
    input logic              reissue_o,
    input logic              err_o,
    input logic [DATA_W-1:0] shad_data,
    input logic              shad_vld
);

    // R10
    one_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({stall_o, flush_o, reissue_o}));

    // R10
    stall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> !stall_o);

    // R10
    flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> !flush_o);

    // R4
    fwd_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> (q_vld_o && (q_o == $past(shad_data))));

    // R6
    flush_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_o |=> !q_vld_o);

    // R9
    bubble_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(q_vld_o && shad_vld) |-> !(err_o || stall_o || flush_o || reissue_o));

    // R2
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b11 || mode_i == 2'b00) |-> !(err_o || stall_o || flush_o || reissue_o));

    // R3
    act_has_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o || flush_o || reissue_o) |-> err_o);

endmodule

bind dual_stage_guard dsg_checker #(.DATA_W(DATA_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .q_o       (q_o),
    .q_vld_o   (q_vld_o),
    .stall_o   (stall_o),
    .flush_o   (flush_o),
    .reissue_o (reissue_o),
    .err_o     (err_o),
    .shad_data (shad_q_data),
    .shad_vld  (shad_q_vld)
);

// File: tb/dual_stage_guard_tb_top.sv
`timescale 1ns/100ps
module dual_stage_guard_tb_top;

    localparam int unsigned W = 16;
    localparam int unsigned NROWS = 20;

    typedef struct packed {
        logic [1:0]   mode;
        logic         vld;
        logic         mark;
        logic [W-1:0] early;
        logic [W-1:0] late;
        logic [W-1:0] sval;
        logic         e_vld;
        logic [W-1:0] e_q;
        logic         e_err;
        logic         e_stall;
        logic         e_act;
    } row_t;

    // mode: 11/00 off, 10 late sampling, 01 full replication.
    // e_act = reissue on the post-scheduling instance, flush on the pre one.
    localparam row_t ROWS [NROWS] = '{
        '{2'b11, 1'b1, 1'b0, 16'h1111, 16'h1111, 16'hFFFF, 1'b1, 16'h1111, 1'b0, 1'b0, 1'b0},
        '{2'b11, 1'b1, 1'b0, 16'h2222, 16'h2AAA, 16'h0000, 1'b1, 16'h2222, 1'b0, 1'b0, 1'b0},
        '{2'b10, 1'b1, 1'b0, 16'h3333, 16'h3333, 16'hDEAD, 1'b1, 16'h3333, 1'b0, 1'b0, 1'b0},
        '{2'b10, 1'b1, 1'b0, 16'h4440, 16'h4441, 16'h0000, 1'b1, 16'h4440, 1'b1, 1'b1, 1'b0},
        '{2'b10, 1'b1, 1'b0, 16'h0BAD, 16'h4441, 16'h0000, 1'b1, 16'h4441, 1'b0, 1'b0, 1'b0},
        '{2'b10, 1'b1, 1'b0, 16'h5555, 16'hD555, 16'h0000, 1'b1, 16'h5555, 1'b1, 1'b1, 1'b0},
        '{2'b10, 1'b1, 1'b0, 16'h5555, 16'hD555, 16'h0000, 1'b1, 16'hD555, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b1, 1'b0, 16'h6666, 16'h6666, 16'h6666, 1'b1, 16'h6666, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b0, 1'b0, 16'h7777, 16'h7777, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b1, 1'b0, 16'h8888, 16'h8888, 16'h8808, 1'b1, 16'h8888, 1'b1, 1'b0, 1'b1},
        '{2'b01, 1'b1, 1'b0, 16'h9999, 16'h9999, 16'h9999, 1'b1, 16'h9999, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b1, 1'b1, 16'h8888, 16'h8888, 16'h8880, 1'b1, 16'h8888, 1'b1, 1'b1, 1'b0},
        '{2'b01, 1'b1, 1'b1, 16'hAAAA, 16'hAAAA, 16'h8880, 1'b1, 16'h8880, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b1, 1'b1, 16'h1357, 16'h1357, 16'h1356, 1'b1, 16'h1357, 1'b1, 1'b0, 1'b1},
        '{2'b01, 1'b1, 1'b0, 16'h0F0F, 16'h0F0F, 16'h0F0F, 1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b1, 1'b1, 16'h2468, 16'h2468, 16'h2468, 1'b1, 16'h2468, 1'b0, 1'b0, 1'b0},
        '{2'b01, 1'b1, 1'b1, 16'h3579, 16'h3579, 16'h3578, 1'b1, 16'h3579, 1'b1, 1'b0, 1'b1},
        '{2'b01, 1'b1, 1'b0, 16'h4242, 16'h4242, 16'h4242, 1'b1, 16'h4242, 1'b0, 1'b0, 1'b0},
        '{2'b11, 1'b1, 1'b0, 16'h1000, 16'h3000, 16'h2000, 1'b1, 16'h1000, 1'b0, 1'b0, 1'b0},
        '{2'b00, 1'b1, 1'b0, 16'h5000, 16'h5001, 16'h5000, 1'b1, 16'h5000, 1'b0, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         late_stb = 1'b0;
    logic [1:0]   mode = 2'b11;
    logic [W-1:0] main_res = '0;
    logic         main_vld = 1'b0;
    logic         main_mark = 1'b0;
    logic [W-1:0] shad_res = '0;
    logic         shad_vld = 1'b0;

    logic [W-1:0] a_q, b_q;
    logic         a_vld, a_stall, a_flush, a_reissue, a_err;
    logic         b_vld, b_stall, b_flush, b_reissue, b_err;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dual_stage_guard #(.DATA_W(W), .LANE_W(4), .AFTER_RS(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .late_stb_i(late_stb), .mode_i(mode),
        .main_res_i(main_res), .main_vld_i(main_vld), .main_mark_i(main_mark),
        .shad_res_i(shad_res), .shad_vld_i(shad_vld),
        .q_o(a_q), .q_vld_o(a_vld), .stall_o(a_stall), .flush_o(a_flush),
        .reissue_o(a_reissue), .err_o(a_err)
    );

    dual_stage_guard #(.DATA_W(W), .LANE_W(4), .AFTER_RS(1'b0)) dut_pre_i (
        .clk_i(clk), .rst_ni(rst_n), .late_stb_i(late_stb), .mode_i(mode),
        .main_res_i(main_res), .main_vld_i(main_vld), .main_mark_i(main_mark),
        .shad_res_i(shad_res), .shad_vld_i(shad_vld),
        .q_o(b_q), .q_vld_o(b_vld), .stall_o(b_stall), .flush_o(b_flush),
        .reissue_o(b_reissue), .err_o(b_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0, 1, 18, 19:   return "R2";
            2, 3:           return "R3";
            4, 6:           return "R4";
            5:              return "R11";
            7, 9, 10, 17:   return "R5";
            8:              return "R9";
            11, 12:         return "R7";
            default:        return "R8";
        endcase
    endfunction

    // Early value before the edge, late value and shadow value before the strobe;
    // returns 3 ns after the edge, where outputs are sampled.
    task automatic run_row(input row_t r);
        mode      = r.mode;
        main_res  = r.early;
        main_vld  = r.vld;
        main_mark = r.mark;
        @(posedge clk);
        #0.5;
        main_res = r.late;
        shad_res = r.sval;
        shad_vld = r.vld;
        #0.5 late_stb = 1'b1;
        #0.5 late_stb = 1'b0;
        #1.5;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main_seq
        row_t r;
        logic prev_act;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        chk(a_vld == 1'b0, "R1", "q_vld in reset", {31'd0, a_vld}, 32'd0);
        chk({a_stall, a_flush, a_reissue, a_err} == 4'b0, "R1", "actions in reset",
            {28'd0, a_stall, a_flush, a_reissue, a_err}, 32'd0);
        rst_n = 1'b1;
        #1;
        // R1 right after release
        chk(a_vld == 1'b0 && b_vld == 1'b0, "R1", "q_vld after reset",
            {30'd0, a_vld, b_vld}, 32'd0);

        prev_act = 1'b0;
        for (int i = 0; i < NROWS; i++) begin
            run_row(ROWS[i]);
            chk(a_vld == ROWS[i].e_vld, row_tag(i), "post q_vld", {31'd0, a_vld}, {31'd0, ROWS[i].e_vld});
            if (ROWS[i].e_vld)
                chk(a_q == ROWS[i].e_q, row_tag(i), "post q", {16'd0, a_q}, {16'd0, ROWS[i].e_q});
            chk(a_err == ROWS[i].e_err, row_tag(i), "post err", {31'd0, a_err}, {31'd0, ROWS[i].e_err});
            chk(a_stall == ROWS[i].e_stall, row_tag(i), "post stall", {31'd0, a_stall}, {31'd0, ROWS[i].e_stall});
            chk(a_reissue == ROWS[i].e_act, row_tag(i), "post reissue", {31'd0, a_reissue}, {31'd0, ROWS[i].e_act});
            chk(a_flush == 1'b0, "R5", "post flush", {31'd0, a_flush}, 32'd0);
            // R6 pre-scheduling variant flushes instead of reissuing
            chk(b_flush == ROWS[i].e_act, "R6", "pre flush", {31'd0, b_flush}, {31'd0, ROWS[i].e_act});
            chk(b_reissue == 1'b0, "R6", "pre reissue", {31'd0, b_reissue}, 32'd0);
            chk(b_stall == ROWS[i].e_stall, row_tag(i), "pre stall", {31'd0, b_stall}, {31'd0, ROWS[i].e_stall});
            if (prev_act)
                chk(b_vld == 1'b0, "R6", "pre word dropped after flush", {31'd0, b_vld}, 32'd0);
            // R10 at most one action per cycle
            chk($countones({a_stall, a_flush, a_reissue}) <= 1 &&
                $countones({b_stall, b_flush, b_reissue}) <= 1, "R10", "single action",
                {26'd0, a_stall, a_flush, a_reissue, b_stall, b_flush, b_reissue}, 32'd0);
            prev_act = ROWS[i].e_act;
        end

        // R9 bubble in late-sampling mode with skewed data
        r = '{2'b10, 1'b0, 1'b0, 16'h00F0, 16'h00F1, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0};
        run_row(r);
        chk(a_err == 1'b0 && a_stall == 1'b0, "R9", "bubble raises nothing",
            {30'd0, a_err, a_stall}, 32'd0);

        // R3 then R1: pending mismatch cleared by asynchronous reset
        r = '{2'b10, 1'b1, 1'b0, 16'hC000, 16'hC003, 16'h0000, 1'b1, 16'hC000, 1'b1, 1'b1, 1'b0};
        run_row(r);
        chk(a_stall == 1'b1 && a_err == 1'b1, "R3", "late mismatch stalls",
            {30'd0, a_stall, a_err}, 32'd3);
        rst_n = 1'b0;
        #0.5;
        chk({a_vld, a_stall, a_err, a_reissue, a_flush} == 5'b0, "R1", "async reset clears",
            {27'd0, a_vld, a_stall, a_err, a_reissue, a_flush}, 32'd0);
        #1.0 rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule